// File: doc/BRIEF.md
# Peripheral Control Line Conditioner

One copy of this block sits beside each DMA channel and gives meaning to the channel's active-low peripheral control line. A two-bit device-class field and a two-bit line-function field together select one role for the line. It can be an enable-clock input for a 6800-style bus device, a ready input, a level status input, an interrupt input, or an abort input that only acts while the channel runs.

The line is asynchronous to the controller clock, which runs at 8 MHz in the target system. It passes through a two-flop synchroniser. The synchronised level is always visible as a status bit. A falling edge only counts after the line has been low for two consecutive synchronised samples, so a one-clock glitch is ignored. A counted edge does one of two things. In status or interrupt role it sets a sticky transition bit, and software clears that bit by writing a one. In abort role, with the channel started, it produces a single-cycle abort pulse. The sticky bit drives the channel interrupt request when interrupts are enabled.

Top module: `pcl_conditioner`

## Requirements
- R1: Device class 2'b01 (6800-style) selects the enable-clock role regardless of the function field: `enclk_o` is the inverted synchronised line level, and no edge ever sets the transition bit or pulses abort.
- R2: Device class 2'b10 (device with ready) selects the ready role regardless of the function field: `ready_o` is the inverted synchronised line level, with no edge effects.
- R3: For device classes 2'b00 and 2'b11 the function field decides the role: 2'b00 status, 2'b01 interrupt, 2'b10 abort, 2'b11 status. In these roles `ready_o` and `enclk_o` stay 0.
- R4: `line_level_o` equals the level of `pcl_n_i` as sampled two clock edges earlier (1 = high), in every role.
- R5: A qualified falling edge is a synchronised high sample followed by two low samples. If the line is first sampled low at clock edge k, `trans_flag_o` reads 1 after edge k+3 in status or interrupt role. A low pulse that is sampled only once sets nothing.
- R6: `trans_flag_o` holds until a cycle with `trans_clr_i` = 1 clears it. If a qualified edge falls in that same cycle, the bit stays set.
- R7: `irq_o` is 1 exactly when `trans_flag_o` is 1 and `int_en_i` is 1.
- R8: In abort role, a qualified edge while `chan_started_i` is 1 produces a `abort_pulse_o` high for exactly one cycle, after edge k+3. An edge while the channel is idle produces no pulse. Abort-role edges never set the transition bit.
- R9: While `rst_n_i` is low, `line_level_o` reads 1 and every other output reads 0. Reset release is synchronised to the clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| pcl_n_i | input | 1 | Active-low peripheral control line, asynchronous |
| dev_type_i | input | 2 | Device class: 01 6800-style, 10 with ready, else generic |
| line_fn_i | input | 2 | Line function for generic devices: 00 status, 01 interrupt, 10 abort, 11 status |
| chan_started_i | input | 1 | Channel has been started (gates abort) |
| int_en_i | input | 1 | Interrupt enable |
| trans_clr_i | input | 1 | Write-one clear strobe for the transition bit |
| line_level_o | output | 1 | Synchronised line level, 1 = high |
| trans_flag_o | output | 1 | Sticky qualified-falling-edge bit |
| irq_o | output | 1 | Channel interrupt request |
| abort_pulse_o | output | 1 | One-cycle abort request to the channel |
| ready_o | output | 1 | Active-high ready (ready role only) |
| enclk_o | output | 1 | Active-high enable clock (6800 role only) |

## Verification
Each result has a fixed latency after the line changes. The level status, ready and enable-clock outputs follow the line two clock edges after it is sampled. The transition bit and the abort pulse respond three edges after the first low sample. The interrupt request follows the transition bit and the enable input with no extra register. The bench holds inputs from one falling clock edge to the next and checks every output at the next falling edge. Its reference keeps a per-edge history of the sampled line, so each expectation lines up with the edge at which the requirement says the output changes. Directed sequences cover a one-sample glitch, a clear that collides with a new edge, abort edges with the channel idle and started, and role overrides by the device class.

// File: rtl/pcl_cond_pkg.sv
package pcl_cond_pkg;

  typedef enum logic [2:0] {
    ROLE_STATUS = 3'd0,
    ROLE_INTR   = 3'd1,
    ROLE_ABORT  = 3'd2,
    ROLE_READY  = 3'd3,
    ROLE_ENCLK  = 3'd4
  } pcl_role_e;

  localparam logic [1:0] DEV_M6800 = 2'b01;
  localparam logic [1:0] DEV_RDY   = 2'b10;

  localparam logic [1:0] FN_STATUS = 2'b00;
  localparam logic [1:0] FN_INTR   = 2'b01;
  localparam logic [1:0] FN_ABORT  = 2'b10;

endpackage

// File: rtl/pcl_rst_sync.sv
module pcl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge arst_n_i) begin
    if (!arst_n_i) chain_q <= '0;
    else           chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/pcl_line_sync.sv
module pcl_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic line_i,
  output logic line_o
);
  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[STAGES-2:0], line_i};
  end

  // idle level of the line is high
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) stage_q <= '1;
    else          stage_q <= stage_d;
  end

  assign line_o = stage_q[STAGES-1];
endmodule

// File: rtl/pcl_edge_qual.sv
module pcl_edge_qual #(
  parameter int STABLE = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic level_i,
  output logic fall_o
);
  localparam int WIN = STABLE + 1;
  localparam logic [WIN-1:0] FALL_PAT = {1'b1, {STABLE{1'b0}}};

  logic [STABLE-1:0] hist_q;
  logic [STABLE-1:0] hist_d;
  logic [WIN-1:0]    window;

  always_comb begin
    hist_d = {hist_q[STABLE-2:0], level_i};
    window = {hist_q, level_i};
    fall_o = (window == FALL_PAT);
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) hist_q <= '1;
    else          hist_q <= hist_d;
  end

  // R5: a qualified fall cannot repeat on the following cycle
  fall_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    fall_o |=> !fall_o);
endmodule

// File: rtl/pcl_role_dec.sv
module pcl_role_dec
  import pcl_cond_pkg::*;
(
  input  logic [1:0] dev_type_i,
  input  logic [1:0] line_fn_i,
  output pcl_role_e  role_o
);
  always_comb begin
    if (dev_type_i == DEV_M6800) begin
      role_o = ROLE_ENCLK;
    end else if (dev_type_i == DEV_RDY) begin
      role_o = ROLE_READY;
    end else begin
      case (line_fn_i)
        FN_INTR:  role_o = ROLE_INTR;
        FN_ABORT: role_o = ROLE_ABORT;
        default:  role_o = ROLE_STATUS;
      endcase
    end
  end
endmodule

// File: rtl/pcl_event_regs.sv
module pcl_event_regs
  import pcl_cond_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_n_i,
  input  logic      fall_i,
  input  pcl_role_e role_i,
  input  logic      started_i,
  input  logic      clr_i,
  output logic      flag_o,
  output logic      abort_o
);
  logic flag_q, flag_d, flag_set;
  logic abort_q, abort_d;

  always_comb begin
    flag_set = fall_i & ((role_i == ROLE_STATUS) | (role_i == ROLE_INTR));
    flag_d   = flag_set | (flag_q & ~clr_i);
    abort_d  = fall_i & (role_i == ROLE_ABORT) & started_i;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      flag_q  <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      flag_q  <= flag_d;
      abort_q <= abort_d;
    end
  end

  assign flag_o  = flag_q;
  assign abort_o = abort_q;

  // R6
  flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (flag_q && !clr_i) |=> flag_q);

  // R5
  flag_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $rose(flag_q) |-> $past(fall_i));

  // R8
  abort_width_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    abort_q |=> !abort_q);

  // R8
  abort_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    abort_q |-> $past(started_i));
endmodule

// File: rtl/pcl_conditioner.sv
module pcl_conditioner
  import pcl_cond_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int STABLE_CLKS  = 2,
  parameter int RST_STAGES   = 2
) (
  input  logic       clk_i,
  input  logic       rst_n_i,
  input  logic       pcl_n_i,
  input  logic [1:0] dev_type_i,
  input  logic [1:0] line_fn_i,
  input  logic       chan_started_i,
  input  logic       int_en_i,
  input  logic       trans_clr_i,
  output logic       line_level_o,
  output logic       trans_flag_o,
  output logic       irq_o,
  output logic       abort_pulse_o,
  output logic       ready_o,
  output logic       enclk_o
);
  logic      rst_n_sync;
  logic      lvl_sync;
  logic      fall_q;
  pcl_role_e role;

  pcl_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk_i   (clk_i),
    .arst_n_i(rst_n_i),
    .rst_n_o (rst_n_sync)
  );

  pcl_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_n_i(rst_n_sync),
    .line_i (pcl_n_i),
    .line_o (lvl_sync)
  );

  pcl_edge_qual #(.STABLE(STABLE_CLKS)) u_qual (
    .clk_i  (clk_i),
    .rst_n_i(rst_n_sync),
    .level_i(lvl_sync),
    .fall_o (fall_q)
  );

  pcl_role_dec u_dec (
    .dev_type_i(dev_type_i),
    .line_fn_i (line_fn_i),
    .role_o    (role)
  );

  pcl_event_regs u_evt (
    .clk_i    (clk_i),
    .rst_n_i  (rst_n_sync),
    .fall_i   (fall_q),
    .role_i   (role),
    .started_i(chan_started_i),
    .clr_i    (trans_clr_i),
    .flag_o   (trans_flag_o),
    .abort_o  (abort_pulse_o)
  );

  always_comb begin
    line_level_o = lvl_sync;
    irq_o        = trans_flag_o & int_en_i;
    ready_o      = (role == ROLE_READY) & ~lvl_sync;
    enclk_o      = (role == ROLE_ENCLK) & ~lvl_sync;
  end

  // R1 R2: ready and enable-clock never both active
  role_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    $onehot0({ready_o, enclk_o}));

  // R8: no abort pulse outside abort role combined with a set flag rise
  abort_noflag_chk: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    abort_pulse_o |-> !$rose(trans_flag_o));
endmodule

// File: tb/pcl_conditioner_tb.sv
module pcl_conditioner_tb_top;
  logic       clk;
  logic       rst_n;
  logic       line_n;
  logic [1:0] dev;
  logic [1:0] fn;
  logic       started;
  logic       int_en;
  logic       clr;
  logic       line_level, trans_flag, irq, abort_pulse, ready, enclk;

  int n_vec;
  int n_bad;
  bit done;

  // reference history of sampled line levels
  logic m_s1, m_s2, m_h0, m_h1, m_flag, m_abort;
  logic [1:0] c_dev, c_fn;
  logic       c_st, c_ie;

  pcl_conditioner dut_i (
    .clk_i         (clk),
    .rst_n_i       (rst_n),
    .pcl_n_i       (line_n),
    .dev_type_i    (dev),
    .line_fn_i     (fn),
    .chan_started_i(started),
    .int_en_i      (int_en),
    .trans_clr_i   (clr),
    .line_level_o  (line_level),
    .trans_flag_o  (trans_flag),
    .irq_o         (irq),
    .abort_pulse_o (abort_pulse),
    .ready_o       (ready),
    .enclk_o       (enclk)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // 0 status, 1 interrupt, 2 abort, 3 ready, 4 enable clock
  function automatic int role_of(input logic [1:0] d, input logic [1:0] f);
    if (d == 2'b01) return 4;
    if (d == 2'b10) return 3;
    if (f == 2'b01) return 1;
    if (f == 2'b10) return 2;
    return 0;
  endfunction

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic check_all();
    int r;
    r = role_of(dev, fn);
    chk("R4", "line_level", line_level, m_s2);
    chk("R5", "trans_flag", trans_flag, m_flag);
    chk("R7", "irq", irq, m_flag & int_en);
    chk("R8", "abort_pulse", abort_pulse, m_abort);
    chk("R2", "ready", ready, (r == 3) && !m_s2);
    chk("R1", "enclk", enclk, (r == 4) && !m_s2);
    if (r < 3) chk("R3", "generic role ready|enclk", ready | enclk, 1'b0);
  endtask

  // drive one cycle at a falling edge, predict, check at the next falling edge
  task automatic step(input logic l, input logic cl);
    logic q;
    int   r;
    line_n = l; dev = c_dev; fn = c_fn; started = c_st; int_en = c_ie; clr = cl;
    q = !m_s2 && !m_h0 && m_h1;
    r = role_of(c_dev, c_fn);
    m_abort = q && (r == 2) && c_st;
    m_flag  = (q && (r == 0 || r == 1)) || (m_flag && !cl);
    m_h1 = m_h0; m_h0 = m_s2; m_s2 = m_s1; m_s1 = l;
    @(negedge clk);
    check_all();
  endtask

  task automatic hold(input logic l, input int n);
    for (int i = 0; i < n; i++) step(l, 1'b0);
  endtask

  initial begin
    done = 1'b0;
    #(8 * 200000);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    n_vec = 0; n_bad = 0;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; line_n = 1'b1; dev = 2'b00; fn = 2'b00;
    started = 1'b0; int_en = 1'b0; clr = 1'b0;
    c_dev = 2'b00; c_fn = 2'b00; c_st = 1'b0; c_ie = 1'b1;
    m_s1 = 1'b1; m_s2 = 1'b1; m_h0 = 1'b1; m_h1 = 1'b1; m_flag = 1'b0; m_abort = 1'b0;

    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9", "reset line_level", line_level, 1'b1);
    chk("R9", "reset trans_flag", trans_flag, 1'b0);
    chk("R9", "reset irq", irq, 1'b0);
    chk("R9", "reset abort", abort_pulse, 1'b0);
    chk("R9", "reset ready", ready, 1'b0);
    chk("R9", "reset enclk", enclk, 1'b0);
    rst_n = 1'b1;
    hold(1'b1, 4);

    // R5: long low in status role sets flag after the third edge
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    chk("R5", "flag not yet set", trans_flag, 1'b0);
    step(1'b0, 1'b0);
    chk("R5", "flag set after k+3", trans_flag, 1'b1);
    chk("R7", "irq with enable", irq, 1'b1);
    c_ie = 1'b0;
    step(1'b0, 1'b0);
    chk("R7", "irq masked", irq, 1'b0);

    // R6: clear with no new edge
    step(1'b0, 1'b1);
    chk("R6", "flag cleared", trans_flag, 1'b0);

    // R5: one-sample glitch is ignored
    hold(1'b1, 3);
    step(1'b0, 1'b0);
    hold(1'b1, 5);
    chk("R5", "glitch ignored", trans_flag, 1'b0);

    // R6: set wins over clear in the same cycle (interrupt role)
    c_fn = 2'b01; c_ie = 1'b1;
    hold(1'b0, 4);
    hold(1'b1, 3);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b1);
    chk("R6", "set beats clear", trans_flag, 1'b1);
    step(1'b0, 1'b1);
    chk("R6", "later clear", trans_flag, 1'b0);

    // R8: abort role, idle then started
    c_fn = 2'b10; c_st = 1'b0;
    hold(1'b1, 3);
    hold(1'b0, 5);
    chk("R8", "no pulse while idle", abort_pulse, 1'b0);
    chk("R8", "abort edge leaves flag", trans_flag, 1'b0);
    c_st = 1'b1;
    hold(1'b1, 3);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    chk("R8", "pulse when started", abort_pulse, 1'b1);
    step(1'b0, 1'b0);
    chk("R8", "pulse one cycle", abort_pulse, 1'b0);

    // R2: ready role overrides function field
    c_dev = 2'b10; c_fn = 2'b01;
    hold(1'b1, 3);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    chk("R2", "ready active", ready, 1'b1);
    hold(1'b0, 3);
    chk("R2", "ready sets no flag", trans_flag, 1'b0);

    // R1: enable-clock role overrides function field
    c_dev = 2'b01; c_fn = 2'b00;
    hold(1'b1, 3);
    chk("R1", "enclk idle", enclk, 1'b0);
    hold(1'b0, 4);
    chk("R1", "enclk active", enclk, 1'b1);
    chk("R1", "enclk sets no flag", trans_flag, 1'b0);

    // constrained random
    begin
      logic lv;
      lv = 1'b1;
      for (int i = 0; i < 4000; i++) begin
        if (i % 32 == 0) begin
          c_dev = 2'($urandom % 4);
          c_fn  = 2'($urandom % 4);
          c_st  = 1'($urandom % 2);
          c_ie  = 1'($urandom % 2);
        end
        if ($urandom % 3 == 0) lv = ~lv;
        step(lv, ($urandom % 10) == 0);
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule